// File: doc/BRIEF.md
# 64B/66B Receive Gearbox

This block sits between a line-side deserialiser and the block-level receive logic, and it runs on the clock that the line side uses. Each cycle it takes one word of line bits, `DATA_W` wide, with the earliest received bit in bit 0. It cuts the stream into 66-bit blocks and hands out each block as a 2-bit sync header plus 64 payload bits. The payload goes out in `DATA_W`-bit words. The header travels alongside the first payload word of its block.

A 66-bit block carries more bits than its payload words hold, so the output falls behind the input. Every 16 blocks the block stops for one or two cycles and flags its output invalid. A start-of-sequence strobe marks the first word of each 16-block sequence. The block does no alignment of its own. External lock logic pulses the slip input, and each pulse drops one line bit, until the headers land in the right place. With the enable input low, the line word goes straight through to the data output.

Two parameters set the variant. `DATA_W` takes 32 or 16. `MODE` takes only 3'b011, which selects 64B/66B with the internal sequence counter. The code 3'b001, which asks for an external counter, is recognised and rejected during elaboration, as is any other code or width.

Top module: `rxgb_6466`

## Requirements
- R1: While `rst_ni` is low, `data_valid_o`, `header_valid_o`, `start_seq_o`, `header_o` and `data_o` are all zero. After reset is released with `en_i` high, the first 32/DATA_W output cycles have `data_valid_o` low, which is one cycle at width 32 and two at width 16.
- R2: A sequence counter steps through 0 to P-1, where P = 1056/DATA_W (33 or 66 cycles). `data_valid_o` is low exactly on counts 64·16/DATA_W to P-1. At width 32 that is one cycle in 33. At width 16 it is two consecutive cycles after every 64 valid words.
- R3: `header_valid_o` is high only on the first output word of each block, which is every 64/DATA_W valid words. On those cycles `header_o[1:0]` holds the two sync bits, with the earlier bit in bit 0, and `header_o[2]` is 0.
- R4: Word k of a block (k from 0) carries payload bits k·DATA_W to k·DATA_W+DATA_W-1, counted after the two sync bits. The earliest bit is in bit 0.
- R5: `start_seq_o` is high exactly on the word shown at count 0, which is always the first word of a block.
- R6: A gearbox start is a reset release, with line words counted from the first rising edge after it, or the rising edge at which `en_i` returns high. In both cases the block stream begins with the word sampled one edge before that first enabled edge, and after reset that word is all zeros. Block b, word k then appears after edge 32/DATA_W + ⌊b/16⌋·P + (b mod 16)·(64/DATA_W) + k, with edges counted from the start.
- R7: A slip sampled high at edge t removes one line bit from the block stream. The removal applies from the line word sampled at edge t+3. Outputs built only from earlier words are unchanged.
- R8: A slip held high for N edges removes N bits in total, one per edge.
- R9: The slip position wraps after 66 slips. The boundary then sits exactly one whole block later, with the same header alignment.
- R10: When `en_i` is low at an edge, the output after that edge has `data_o` equal to the slipped line word sampled one edge earlier, `data_valid_o` high, and `header_valid_o` and `start_seq_o` low. The gearbox is also restarted as described in R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shared line and output clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Gearbox enable; low selects pass-through |
| slip_i | input | 1 | Drop one line bit per cycle held high |
| rx_data_i | input | DATA_W | Line word, earliest bit in bit 0 |
| data_o | output | DATA_W | Payload word |
| header_o | output | 3 | Sync header in bits 1:0, bit 2 zero |
| data_valid_o | output | 1 | `data_o` holds a payload word |
| header_valid_o | output | 1 | `header_o` holds a sync header |
| start_seq_o | output | 1 | Word shown is at sequence count 0 |

## Verification
A line word sampled at edge t reaches the gearbox after edge t+1. A pass-through word appears after the edge that follows its own sampling. A slip changes the extraction offset at edge t+2 and the words built from edge t+3 onward. The bench drives every input after a falling edge and records, for each rising edge, the word, the enable and the offset that the requirements imply. It then samples all outputs of a 32-bit and a 16-bit instance at the next falling edge. Each output is compared with a bit-level model indexed by that edge number, so every latency is checked at its exact cycle and not after a settling delay.

// File: rtl/rxgb_pkg.sv
package rxgb_pkg;
  localparam int BLOCK_W    = 66;
  localparam int SYNC_W     = 2;
  localparam int PAYLOAD_W  = BLOCK_W - SYNC_W;
  localparam int SEQ_BLOCKS = 16;
  localparam int OFS_W      = $clog2(BLOCK_W);

  localparam logic [2:0] MODE_INT_66 = 3'b011;
  localparam logic [2:0] MODE_EXT_66 = 3'b001;

  typedef logic [OFS_W-1:0] ofs_t;
endpackage

// File: rtl/rxgb_bit_align.sv
module rxgb_bit_align
  import rxgb_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         slip_i,
  input  logic [W-1:0] line_i,
  output logic [W-1:0] word_o
);
  localparam int HIST  = ((BLOCK_W + W - 1) / W) * W;
  localparam int WIN   = HIST + W;
  localparam int IDX_W = $clog2(WIN + 1);

  logic [HIST-1:0]  hist_q;
  logic [WIN-1:0]   win;
  logic [IDX_W-1:0] base;
  logic [1:0]       slip_q;
  ofs_t             ofs_q;
  logic [W-1:0]     word_q;

  assign win  = {line_i, hist_q};
  // larger offset = older bits; ofs 0 picks the word just sampled
  assign base = IDX_W'(HIST) - IDX_W'(ofs_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
      slip_q <= '0;
      ofs_q  <= '0;
      word_q <= '0;
    end else begin
      hist_q <= win[WIN-1:W];
      slip_q <= {slip_q[0], slip_i};
      if (slip_q[1]) ofs_q <= (ofs_q == '0) ? ofs_t'(BLOCK_W - 1) : ofs_q - ofs_t'(1);
      word_q <= win[base +: W];
    end
  end

  assign word_o = word_q;
endmodule

// File: rtl/rxgb_core.sv
module rxgb_core
  import rxgb_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [W-1:0]      word_i,
  output logic [W-1:0]      data_o,
  output logic [SYNC_W-1:0] header_o,
  output logic              data_valid_o,
  output logic              header_valid_o,
  output logic              start_seq_o
);
  localparam int WPB      = PAYLOAD_W / W;
  localparam int VALID    = SEQ_BLOCKS * WPB;
  localparam int PERIOD   = SEQ_BLOCKS * BLOCK_W / W;
  localparam int GAP_BITS = (PERIOD - VALID) * W;
  localparam int BUF_W    = GAP_BITS + W;
  localparam int CNT_W    = $clog2(PERIOD);
  localparam int FILL_W   = $clog2(BUF_W + 1);

  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [FILL_W-1:0] fill_q, take;
  logic [BUF_W-1:0]  buf_q, cat;
  logic              gap, first;

  assign gap   = cnt_q >= CNT_W'(VALID);
  assign first = (cnt_q % CNT_W'(WPB)) == '0;
  assign cat   = buf_q | ({{(BUF_W-W){1'b0}}, word_i} << fill_q);
  assign cnt_n = (cnt_q == CNT_W'(PERIOD - 1)) ? '0 : cnt_q + CNT_W'(1);

  always_comb begin
    if (gap)        take = '0;
    else if (first) take = FILL_W'(W + SYNC_W);
    else            take = FILL_W'(W);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q          <= CNT_W'(VALID);
      fill_q         <= '0;
      buf_q          <= '0;
      data_o         <= '0;
      header_o       <= '0;
      data_valid_o   <= 1'b0;
      header_valid_o <= 1'b0;
      start_seq_o    <= 1'b0;
    end else if (!en_i) begin
      // pass-through; gearbox held at its start state
      cnt_q          <= CNT_W'(VALID);
      fill_q         <= '0;
      buf_q          <= '0;
      data_o         <= word_i;
      header_o       <= '0;
      data_valid_o   <= 1'b1;
      header_valid_o <= 1'b0;
      start_seq_o    <= 1'b0;
    end else begin
      cnt_q          <= cnt_n;
      fill_q         <= fill_q + FILL_W'(W) - take;
      buf_q          <= cat >> take;
      data_valid_o   <= !gap;
      header_valid_o <= !gap && first;
      start_seq_o    <= cnt_q == '0;
      if (!gap) data_o <= first ? cat[SYNC_W +: W] : cat[0 +: W];
      if (!gap && first) header_o <= cat[SYNC_W-1:0];
    end
  end
endmodule

// File: rtl/rxgb_6466.sv
module rxgb_6466
  import rxgb_pkg::*;
#(
  parameter int         DATA_W = 32,
  parameter logic [2:0] MODE   = MODE_INT_66
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              slip_i,
  input  logic [DATA_W-1:0] rx_data_i,
  output logic [DATA_W-1:0] data_o,
  output logic [2:0]        header_o,
  output logic              data_valid_o,
  output logic              header_valid_o,
  output logic              start_seq_o
);
  if (DATA_W != 32 && DATA_W != 16) begin : g_bad_width
    $error("rxgb_6466: DATA_W must be 32 or 16");
  end
  if (MODE == MODE_EXT_66) begin : g_ext_mode
    $error("rxgb_6466: external sequence counter mode not implemented");
  end else if (MODE != MODE_INT_66) begin : g_bad_mode
    $error("rxgb_6466: unsupported MODE");
  end

  logic [DATA_W-1:0] al_word;
  logic [SYNC_W-1:0] sync_hdr;

  rxgb_bit_align #(.W(DATA_W)) align_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .slip_i (slip_i),
    .line_i (rx_data_i),
    .word_o (al_word)
  );

  rxgb_core #(.W(DATA_W)) core_i (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .en_i           (en_i),
    .word_i         (al_word),
    .data_o         (data_o),
    .header_o       (sync_hdr),
    .data_valid_o   (data_valid_o),
    .header_valid_o (header_valid_o),
    .start_seq_o    (start_seq_o)
  );

  assign header_o = {1'b0, sync_hdr};
endmodule

// File: rtl/rxgb_6466_chk.sv
module rxgb_6466_chk
  import rxgb_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       en_i,
  input logic [2:0] header_o,
  input logic       data_valid_o,
  input logic       header_valid_o,
  input logic       start_seq_o
);
  localparam int WPB    = PAYLOAD_W / DATA_W;
  localparam int VALID  = SEQ_BLOCKS * WPB;
  localparam int PERIOD = SEQ_BLOCKS * BLOCK_W / DATA_W;

  // position of the shown word since the last observed start, 0 = unknown
  logic [7:0] since_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  since_q <= '0;
    else if (!en_i)                               since_q <= '0;
    else if (start_seq_o)                         since_q <= 8'd1;
    else if (since_q != '0 && since_q < PERIOD)   since_q <= since_q + 8'd1;
  end

  // R2
  valid_cadence_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_q != '0 && since_q < PERIOD) |-> (data_valid_o == (since_q < VALID)));

  // R3
  hdr_cadence_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_q != '0 && since_q < VALID) |-> (header_valid_o == ((since_q % WPB) == 0)));

  // R3
  hv_needs_dv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    header_valid_o |-> data_valid_o);

  // R3
  hdr_msb_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    header_valid_o |-> !header_o[2]);

  // R5
  sos_block_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_seq_o |-> (header_valid_o && data_valid_o));

  // R10
  bypass_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (data_valid_o && !header_valid_o && !start_seq_o));
endmodule

bind rxgb_6466 rxgb_6466_chk #(.DATA_W(DATA_W)) chk_i (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .en_i           (en_i),
  .header_o       (header_o),
  .data_valid_o   (data_valid_o),
  .header_valid_o (header_valid_o),
  .start_seq_o    (start_seq_o)
);

// File: tb/rxgb_6466_tb_top.sv
module rxgb_6466_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_ni = 1'b0;
  logic        en = 1'b1;
  logic        slip = 1'b0;
  logic [31:0] d32 = '0;
  logic [15:0] d16 = '0;

  logic [31:0] o32_data; logic [2:0] o32_hdr; logic o32_dv, o32_hv, o32_sos;
  logic [15:0] o16_data; logic [2:0] o16_hdr; logic o16_dv, o16_hv, o16_sos;

  rxgb_6466 #(.DATA_W(32)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .slip_i(slip), .rx_data_i(d32),
    .data_o(o32_data), .header_o(o32_hdr), .data_valid_o(o32_dv),
    .header_valid_o(o32_hv), .start_seq_o(o32_sos));

  rxgb_6466 #(.DATA_W(16)) dut16_i (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .slip_i(slip), .rx_data_i(d16),
    .data_o(o16_data), .header_o(o16_hdr), .data_valid_o(o16_dv),
    .header_valid_o(o16_hv), .start_seq_o(o16_sos));

  int errors = 0;
  int checks = 0;
  int cur;
  int s0;
  int e_now;
  int e_at[0:4095];
  bit slip_at[0:4095];
  bit en_at[0:4095];

  function automatic bit line_bit(int n);
    int b, j;
    b = n / 66;
    j = n % 66;
    if (j == 0) return (b % 2 == 0);
    if (j == 1) return (b % 2 != 0);
    return ((b * 1103 + j * 97 + (b * j) % 13) % 5) < 2;
  endfunction

  function automatic logic [31:0] line_word(int w, int t);
    logic [31:0] v = '0;
    for (int i = 0; i < w; i++) v[i] = line_bit(t * w + i);
    return v;
  endfunction

  // slipped line word sampled at edge t
  function automatic logic [31:0] al_word(int w, int t);
    logic [31:0] v = '0;
    if (t < 0) return v;
    for (int i = 0; i < w; i++) begin
      int pos = t * w + i - e_at[t];
      v[i] = (pos < 0) ? 1'b0 : line_bit(pos);
    end
    return v;
  endfunction

  // bit m of the block stream since the gearbox start s0
  function automatic bit gear_bit(int w, int m);
    int t = s0 - 1 + m / w;
    int pos;
    if (t < 0) return 1'b0;
    pos = t * w + m % w - e_at[t];
    return (pos < 0) ? 1'b0 : line_bit(pos);
  endfunction

  task automatic chk(string tag, string fld, int w, int s, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s w=%0d edge=%0d got=%h exp=%h", tag, fld, w, s, got, exp);
    end
  endtask

  task automatic verify_w(string tag, int w, int s, logic [31:0] gd, logic [2:0] gh,
                          logic gdv, logic ghv, logic gsos);
    int wpb = 64 / w;
    int valid = 16 * wpb;
    int per = 1056 / w;
    int g = per - valid;
    logic [31:0] ed;
    logic [1:0] eh;
    logic edv, ehv, esos;
    ed = '0; eh = '0;
    if (!en_at[s]) begin
      ed = al_word(w, s - 1);
      chk(tag, "R10 bypass data", w, s, gd, ed);
      chk(tag, "R10 bypass flags", w, s, {29'd0, gdv, ghv, gsos}, 32'b100);
    end else begin
      int n = s - s0;
      int cnt = (valid + n) % per;
      edv = cnt < valid; ehv = 1'b0; esos = 1'b0;
      if (edv) begin
        int r = n - g;
        int b = (r / per) * 16 + (r % per) / wpb;
        int k = (r % per) % wpb;
        ehv = (k == 0);
        esos = ((r % per) == 0);
        for (int i = 0; i < w; i++) ed[i] = gear_bit(w, 66 * b + 2 + k * w + i);
        eh[0] = gear_bit(w, 66 * b);
        eh[1] = gear_bit(w, 66 * b + 1);
        chk(tag, "R4 data", w, s, gd, ed);
      end
      chk(tag, "R2 valid", w, s, {31'd0, gdv}, {31'd0, edv});
      chk(tag, "R3 hvalid", w, s, {31'd0, ghv}, {31'd0, ehv});
      chk(tag, "R5 start", w, s, {31'd0, gsos}, {31'd0, esos});
      if (ehv) chk(tag, "R3 header", w, s, {29'd0, gh}, {29'd0, 1'b0, eh});
    end
  endtask

  task automatic tick(string tag, bit sl);
    slip = sl;
    d32 = line_word(32, cur);
    d16 = line_word(16, cur)[15:0];
    slip_at[cur] = sl;
    e_at[cur] = e_now;
    en_at[cur] = en;
    @(posedge clk);
    if (cur >= 2 && slip_at[cur - 2]) e_now = (e_now == 0) ? 65 : e_now - 1;
    @(negedge clk);
    verify_w(tag, 32, cur, o32_data, o32_hdr, o32_dv, o32_hv, o32_sos);
    verify_w(tag, 16, cur, {16'd0, o16_data}, o16_hdr, o16_dv, o16_hv, o16_sos);
    cur++;
  endtask

  task automatic run(string tag, int n);
    for (int i = 0; i < n; i++) tick(tag, 1'b0);
  endtask

  task automatic do_reset(bit en_v);
    @(negedge clk);
    rst_ni = 1'b0; en = en_v; slip = 1'b0; d32 = '0; d16 = '0;
    repeat (2) @(negedge clk);
    // R1: everything cleared while in reset
    chk("R1", "R1 reset32", 32, -1, {o32_data[28:0], o32_hdr} | {29'd0, o32_dv, o32_hv, o32_sos}, '0);
    chk("R1", "R1 reset16", 16, -1, {13'd0, o16_data, o16_hdr} | {29'd0, o16_dv, o16_hv, o16_sos}, '0);
    rst_ni = 1'b1;
    cur = 0; e_now = 0; s0 = 0;
  endtask

  task automatic test_reset;  // R1
    do_reset(1'b1);
    run("R1", 4);
    run("R1", 40);
  endtask

  task automatic test_stream;  // R2 R3 R4 R5 R6 over several sequences
    do_reset(1'b1);
    run("R6", 3 * 66 + 5);
  endtask

  task automatic test_slip_one;  // R7
    do_reset(1'b1);
    run("R7", 50);
    tick("R7", 1'b1);
    run("R7", 120);
  endtask

  task automatic test_slip_burst;  // R8
    do_reset(1'b1);
    run("R8", 40);
    for (int i = 0; i < 5; i++) tick("R8", 1'b1);
    run("R8", 130);
  endtask

  task automatic test_slip_wrap;  // R9
    do_reset(1'b1);
    run("R9", 10);
    for (int i = 0; i < 66; i++) tick("R9", 1'b1);
    run("R9", 140);
  endtask

  task automatic test_bypass;  // R10
    do_reset(1'b0);
    run("R10", 30);
    en = 1'b1;
    s0 = cur;
    run("R10", 140);
  endtask

  initial begin
    test_reset();
    test_stream();
    test_slip_one();
    test_slip_burst();
    test_slip_wrap();
    test_bypass();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule